// File: doc/BRIEF.md
# Pulse-Width Addressed Hybrid Shunt Controller

Several hybrids share one command wire. This controller sits on one hybrid and decides whether that hybrid is shorted by its bypass shunt or left running. The bits on the wire are carried by pulse width. A pulse's width is measured in sampling-clock cycles, and the pulse is classed as a short zero, a long one, a glitch to discard, or an overlong pulse that breaks the frame. Five accepted pulses make a frame. The first four are the target address, sent most significant bit first, and the fifth is the command bit. If the address equals the controller's strapped address, a command bit of one shorts the hybrid and a zero releases it.

An over-voltage flag shorts the hybrid with no command. The short then stays in place until the flag is low and an addressed release frame arrives. After reset the hybrid is shorted, so each hybrid stays bypassed until it is commanded on. Each addressed frame produces a one-cycle strobe, which shows that the decode took place.

Top module: `shunt_cmd_ctrl`

## Requirements
- R1: After reset `shuntEn` is 1 and `frameStrobe` is 0, and they hold these values until a frame or the over-voltage flag changes them.
- R2: A high pulse of GLITCH_MAX (2) sampling cycles or fewer is discarded. It neither adds a bit nor breaks the frame in progress.
- R3: A pulse of 3 to BIT_THRESH (12) cycles decodes as 0, and a pulse of 13 to LONG_MAX (37) cycles decodes as 1. A frame is five decoded bits: the address with its MSB first, then the command bit.
- R4: When the frame address equals `strapAddr` and the flag is low, command bit 1 sets `shuntEn` and command bit 0 clears it.
- R5: A frame whose address differs from `strapAddr` changes neither `shuntEn` nor `frameStrobe`.
- R6: A pulse longer than LONG_MAX (38 cycles or more) discards the partial frame, and the next pulse starts a fresh frame.
- R7: If the line stays low for GAP_TIMEOUT (64) cycles inside a partial frame, that frame is discarded.
- R8: While `ovFlag` is high, `shuntEn` is 1 from the cycle after the flag is first seen.
- R9: After an over-voltage event, `shuntEn` stays 1 once the flag drops. An addressed release that arrives while the flag is high has no effect. `shuntEn` only clears on an addressed release taken with the flag low.
- R10: Every frame that carries the controller's address raises `frameStrobe` for exactly one cycle, including a release that is refused. `shuntEn` can only fall in a cycle where the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdLine | input | 1 | Conditioned pulse-width command line (asynchronous, synchronised inside) |
| strapAddr | input | ADDR_W | Strapped address of this hybrid |
| ovFlag | input | 1 | Over-voltage sense flag, synchronous to clk |
| shuntEn | output | 1 | 1 = hybrid shorted by the shunt |
| frameStrobe | output | 1 | One-cycle pulse per addressed frame |

## Verification
Two things can land in the same cycle: an addressed release being taken and the over-voltage flag rising. The bench first shorts the hybrid with a command. It then sends a release frame and raises the flag at several cycle offsets around the fall of the last pulse, so the flag arrives before, during and after the release is decoded. In every case the result must be a shorted hybrid with exactly one strobe for the frame. The release must then succeed only after the flag has dropped.

// File: rtl/shunt_pkg.sv
package shunt_pkg;

  // Datapath-to-control status strobes, valid for one cycle
  typedef struct packed {
    logic pulseDone;   // falling edge of a measured pulse
    logic pulseBit;    // width above the bit threshold
    logic pulseGlitch; // width too short to count
    logic pulseLong;   // width beyond the longest legal pulse
    logic gapExpired;  // idle timeout inside a partial frame
  } dpStat_t;

  // Control-to-datapath strobes and levels
  typedef struct packed {
    logic shiftEn;  // push pulseBit into the frame register
    logic frameClr; // drop the partial frame
    logic inFrame;  // a partial frame is pending
  } ctlCmd_t;

endpackage

// File: rtl/shunt_pulse_dp.sv
module shunt_pulse_dp
  import shunt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_MAX  = 2,
  parameter int BIT_THRESH  = 12,
  parameter int LONG_MAX    = 37,
  parameter int GAP_TIMEOUT = 64,
  parameter int FRAME_W     = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lineIn,
  input  ctlCmd_t            cmd,
  output dpStat_t            stat,
  output logic [FRAME_W-1:0] frameBits
);

  localparam int WIDTH_W = $clog2(LONG_MAX + 2);
  localparam int GAP_W   = $clog2(GAP_TIMEOUT + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineNow;
  logic                   lineDly;
  logic [WIDTH_W-1:0]     widthCnt;
  logic [GAP_W-1:0]       gapCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ   <= '0;
      lineDly <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], lineIn};
      lineDly <= lineNow;
    end
  end

  assign lineNow = syncQ[SYNC_STAGES-1];

  // Width counter: counts high cycles, saturates one past the longest legal width
  always_ff @(posedge clk) begin
    if (rst) begin
      widthCnt <= '0;
    end else if (lineNow) begin
      if (widthCnt != WIDTH_W'(LONG_MAX + 1)) widthCnt <= widthCnt + 1'b1;
    end else begin
      widthCnt <= '0;
    end
  end

  // Idle-gap counter, only runs while a partial frame is pending
  always_ff @(posedge clk) begin
    if (rst || lineNow || !cmd.inFrame) begin
      gapCnt <= '0;
    end else if (gapCnt != GAP_W'(GAP_TIMEOUT)) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  always_comb begin
    stat.pulseDone   = lineDly & ~lineNow;
    stat.pulseGlitch = widthCnt <= WIDTH_W'(GLITCH_MAX);
    stat.pulseLong   = widthCnt >  WIDTH_W'(LONG_MAX);
    stat.pulseBit    = widthCnt >  WIDTH_W'(BIT_THRESH);
    stat.gapExpired  = cmd.inFrame & ~lineNow & (gapCnt == GAP_W'(GAP_TIMEOUT - 1));
  end

  // Frame shift register, newest bit at the LSB
  always_ff @(posedge clk) begin
    if (rst || cmd.frameClr) begin
      frameBits <= '0;
    end else if (cmd.shiftEn) begin
      frameBits <= {frameBits[FRAME_W-2:0], stat.pulseBit};
    end
  end

  // The width measure restarts after every pulse end (R3)
  p_width_restart_r3: assert property (@(posedge clk) disable iff (rst)
    stat.pulseDone |=> (widthCnt == '0));

  // A saturated width stays saturated while the line is high (R6)
  p_width_sat_r6: assert property (@(posedge clk) disable iff (rst)
    (lineNow && widthCnt == WIDTH_W'(LONG_MAX + 1)) |=> $stable(widthCnt));

endmodule

// File: rtl/shunt_frame_ctl.sv
module shunt_frame_ctl
  import shunt_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int FRAME_W = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  dpStat_t            stat,
  input  logic [FRAME_W-1:0] frameBits,
  input  logic [ADDR_W-1:0]  strapAddr,
  input  logic               ovFlag,
  output ctlCmd_t            cmd,
  output logic               shuntEn,
  output logic               frameStrobe
);

  localparam int CNT_W = $clog2(FRAME_W);

  logic [CNT_W-1:0] bitCnt;
  logic             frameReady;
  logic             goodPulse;
  logic             abortFrame;
  logic             lastBit;
  logic             addrHit;

  always_comb begin
    goodPulse    = stat.pulseDone & ~stat.pulseGlitch & ~stat.pulseLong;
    abortFrame   = (stat.pulseDone & stat.pulseLong) | stat.gapExpired;
    lastBit      = bitCnt == CNT_W'(FRAME_W - 1);
    cmd.shiftEn  = goodPulse & ~abortFrame;
    cmd.frameClr = abortFrame;
    cmd.inFrame  = bitCnt != '0;
    addrHit      = frameReady & (frameBits[FRAME_W-1:1] == strapAddr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt     <= '0;
      frameReady <= 1'b0;
    end else begin
      frameReady <= goodPulse & ~abortFrame & lastBit;
      if (abortFrame)     bitCnt <= '0;
      else if (goodPulse) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
    end
  end

  // Shunt state: reset shorted, over-voltage forces and holds the short
  always_ff @(posedge clk) begin
    if (rst) begin
      shuntEn     <= 1'b1;
      frameStrobe <= 1'b0;
    end else begin
      frameStrobe <= addrHit;
      if (ovFlag)       shuntEn <= 1'b1;
      else if (addrHit) shuntEn <= frameBits[0];
    end
  end

  p_glitch_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (stat.pulseDone && stat.pulseGlitch) |=> $stable(bitCnt));

  p_long_abort_r6: assert property (@(posedge clk) disable iff (rst)
    (stat.pulseDone && stat.pulseLong) |=> (bitCnt == '0 && !frameReady));

  p_gap_abort_r7: assert property (@(posedge clk) disable iff (rst)
    stat.gapExpired |=> (bitCnt == '0));

  p_ov_short_r8: assert property (@(posedge clk) disable iff (rst)
    ovFlag |=> shuntEn);

  p_release_strobed_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(shuntEn) |-> frameStrobe);

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (rst)
    frameStrobe |=> !frameStrobe);

endmodule

// File: rtl/shunt_cmd_ctrl.sv
module shunt_cmd_ctrl #(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_MAX  = 2,
  parameter int BIT_THRESH  = 12,
  parameter int LONG_MAX    = 37,
  parameter int GAP_TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdLine,
  input  logic [ADDR_W-1:0] strapAddr,
  input  logic              ovFlag,
  output logic              shuntEn,
  output logic              frameStrobe
);

  localparam int FRAME_W = ADDR_W + 1;

  shunt_pkg::dpStat_t   dpStat;
  shunt_pkg::ctlCmd_t   ctlCmd;
  logic [FRAME_W-1:0]   frameBits;

  shunt_pulse_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .GLITCH_MAX (GLITCH_MAX),
    .BIT_THRESH (BIT_THRESH),
    .LONG_MAX   (LONG_MAX),
    .GAP_TIMEOUT(GAP_TIMEOUT),
    .FRAME_W    (FRAME_W)
  ) i_dp (
    .clk      (clk),
    .rst      (rst),
    .lineIn   (cmdLine),
    .cmd      (ctlCmd),
    .stat     (dpStat),
    .frameBits(frameBits)
  );

  shunt_frame_ctl #(
    .ADDR_W (ADDR_W),
    .FRAME_W(FRAME_W)
  ) i_ctl (
    .clk        (clk),
    .rst        (rst),
    .stat       (dpStat),
    .frameBits  (frameBits),
    .strapAddr  (strapAddr),
    .ovFlag     (ovFlag),
    .cmd        (ctlCmd),
    .shuntEn    (shuntEn),
    .frameStrobe(frameStrobe)
  );

endmodule

// File: tb/test_shunt_cmd_ctrl.sv
module test_shunt_cmd_ctrl;

  localparam int OWN_ADDR = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmdLine = 1'b0;
  logic [3:0] strapAddr = 4'(OWN_ADDR);
  logic       ovFlag = 1'b0;
  logic       shuntEn;
  logic       frameStrobe;

  int vectors = 0;
  int misses  = 0;
  int strobeCnt = 0;
  int expStrobes = 0;
  logic expShunt = 1'b1;
  bit finished = 0;

  always #4 clk = ~clk;

  shunt_cmd_ctrl i_shunt_cmd_ctrl (
    .clk(clk), .rst(rst), .cmdLine(cmdLine), .strapAddr(strapAddr),
    .ovFlag(ovFlag), .shuntEn(shuntEn), .frameStrobe(frameStrobe)
  );

  always @(negedge clk) if (!rst && frameStrobe) strobeCnt++;

  // Model of the shunt after an addressed frame or an over-voltage condition
  function automatic logic modelShunt(logic cur, logic hit, logic data, logic ov);
    if (ov) return 1'b1;
    if (hit) return data;
    return cur;
  endfunction

  function automatic int widthFor(logic b);
    return b ? int'($urandom_range(37, 13)) : int'($urandom_range(12, 3));
  endfunction

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(int w);
    @(negedge clk) cmdLine = 1'b1;
    repeat (w) @(negedge clk);
    cmdLine = 1'b0;
  endtask

  task automatic sendBit(logic b);
    pulse(widthFor(b));
    repeat (6) @(negedge clk);
  endtask

  task automatic sendFrame(int addr, logic data);
    for (int i = 3; i >= 0; i--) sendBit(addr[i]);
    sendBit(data);
  endtask

  // Addressed-frame bookkeeping for the bench model
  task automatic frameAndCheck(string tag, int addr, logic data);
    logic hit = (addr == OWN_ADDR);
    sendFrame(addr, data);
    repeat (12) @(negedge clk);
    if (hit) expStrobes++;
    expShunt = modelShunt(expShunt, hit, data, ovFlag);
    check({tag, " shunt"}, shuntEn, expShunt);
    check({tag, " strobes"}, strobeCnt, expStrobes);
  endtask

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      misses++;
      vectors++;
      $display("FAIL watchdog actual=timeout expected=done");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset shunt", shuntEn, 1);
    check("R1 reset strobe", frameStrobe, 0);

    // R4 release, then short, by own address
    frameAndCheck("R4 release", OWN_ADDR, 1'b0);
    frameAndCheck("R4 short", OWN_ADDR, 1'b1);
    frameAndCheck("R4 release2", OWN_ADDR, 1'b0);

    // R5 other address ignored
    frameAndCheck("R5 foreign short", 4'hC, 1'b1);

    // R3 boundary widths: 3 and 12 -> 0, 13 and 37 -> 1 ; address 0111 = 7
    pulse(3);  repeat (6) @(negedge clk);
    pulse(13); repeat (6) @(negedge clk);
    pulse(37); repeat (6) @(negedge clk);
    pulse(13); repeat (6) @(negedge clk);
    pulse(12); repeat (18) @(negedge clk);
    expStrobes++;
    expShunt = 1'b0;
    check("R3 edge widths strobe", strobeCnt, expStrobes);
    check("R3 edge widths shunt", shuntEn, 0);

    // R2 glitches between bits must not count: short with glitches inserted
    sendBit(1'b0);
    pulse(2); repeat (6) @(negedge clk);
    sendBit(1'b1);
    pulse(1); repeat (6) @(negedge clk);
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b1);
    repeat (12) @(negedge clk);
    expStrobes++;
    expShunt = 1'b1;
    check("R2 glitch ignored shunt", shuntEn, 1);
    check("R2 glitch ignored strobe", strobeCnt, expStrobes);

    // R6 long pulse discards partial "1,1"
    sendBit(1'b1); sendBit(1'b1);
    pulse(38); repeat (6) @(negedge clk);
    frameAndCheck("R6 after long pulse", OWN_ADDR, 1'b0);

    // R7 idle gap discards partial "1,1"
    sendBit(1'b1); sendBit(1'b1);
    repeat (100) @(negedge clk);
    frameAndCheck("R7 after gap", OWN_ADDR, 1'b1);
    frameAndCheck("R7 release", OWN_ADDR, 1'b0);

    // R8 over-voltage shorts the hybrid
    @(negedge clk) ovFlag = 1'b1;
    @(negedge clk);
    check("R8 ov short", shuntEn, 1);
    expShunt = 1'b1;
    // R9 release refused while flag high; strobe still counted (R10)
    frameAndCheck("R9 release under ov", OWN_ADDR, 1'b0);
    @(negedge clk) ovFlag = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 latched after ov drop", shuntEn, 1);
    frameAndCheck("R9 release after ov", OWN_ADDR, 1'b0);

    // Same-cycle case: flag rises around the decode of a release
    for (int k = 0; k < 6; k++) begin
      frameAndCheck("R10 prep short", OWN_ADDR, 1'b1);
      for (int i = 3; i >= 0; i--) sendBit(OWN_ADDR[i]);
      pulse(widthFor(1'b0));
      repeat (k) @(negedge clk);
      ovFlag = 1'b1;
      repeat (12) @(negedge clk);
      expStrobes++;
      expShunt = 1'b1;
      check("R8 collide shunt", shuntEn, 1);
      check("R10 collide strobe", strobeCnt, expStrobes);
      @(negedge clk) ovFlag = 1'b0;
      frameAndCheck("R9 collide release", OWN_ADDR, 1'b0);
    end

    // Random frames with occasional over-voltage events
    for (int n = 0; n < 40; n++) begin
      int addr = ($urandom_range(2, 0) == 0) ? int'($urandom_range(11, 0)) : OWN_ADDR;
      logic data = 1'($urandom_range(1, 0));
      if ($urandom_range(7, 0) == 0) begin
        @(negedge clk) ovFlag = 1'b1;
        @(negedge clk);
        expShunt = 1'b1;
      end else if (ovFlag && $urandom_range(1, 0) == 1) begin
        @(negedge clk) ovFlag = 1'b0;
      end
      frameAndCheck("R4 random", addr, data);
    end

    finished = 1;
    finishRun();
  end

endmodule